// File: doc/BRIEF.md
# Phase-Offset Square-Wave Channel Driver

This block produces a set of parallel digital square waves at an ultrasonic carrier frequency. All channels share one period counter. Each channel has its own delay, given in clock cycles, that moves its wave later within the period. The waves are built directly in logic as 50% duty pulses, so no converter is needed. An external power stage raises each output to the voltage the emitter needs.

New delay values are written one channel at a time into a shadow bank through a plain write port. A commit strobe arms a transfer. The delays in use are replaced only on the clock edge where the period counter wraps to zero. Frames can therefore change many thousands of times a second without stopping the carrier and without producing a runt pulse. A carrier select input picks one of two carrier frequencies, and the counter takes the new choice only at a wrap. An enable input forces every output low while the counter keeps running.

The update logic is a two-state machine. In `BANK_IDLE` no transfer is pending. The transition *arm*, taken on a commit, leads to `BANK_ARMED`. The transition *swap*, taken on the next wrap, copies the shadow bank into the active bank and returns to `BANK_IDLE`. Any other case is a *hold* in the current state.

Top module: `phased_sqwave_drv`

## Requirements
- R1: While reset is asserted and on the first edge after release, every output is 0. Reset sets the counter to 0, selects the fast carrier period and clears all active and shadow delays to 0.
- R2: The period counter steps by one per clock from 0 to P-1 and then wraps to 0. P is CLK_HZ/CAR_FAST_HZ when the carrier select is 0 and CLK_HZ/CAR_SLOW_HZ when it is 1.
- R3: Each output is registered. After each edge, channel i is 1 when enable is high and ((c - d_i) mod P) < floor(P/2). Here c is the counter value, d_i is the active delay of channel i and P is the period, all taken before that edge.
- R4: An active delay that is equal to or larger than P is used as (d_i mod P).
- R5: A write (wr_en=1) puts wr_delay into the shadow entry of channel wr_ch and has no effect on any output until it has been committed.
- R6: A commit in BANK_IDLE arms the transfer, even on a wrap edge. The shadow bank becomes active on the next wrap edge after that, where the counter goes from P-1 to 0. Any commit while armed is absorbed.
- R7: The carrier select is sampled only on a wrap edge. A change in the middle of a period leaves the current period length unchanged.
- R8: With enable low, all outputs are 0 after the next edge. The counter and the delay banks keep running, so phase is kept when enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Output enable; low forces every output to 0 |
| sel_slow | input | 1 | Carrier select: 0 fast carrier, 1 slow carrier |
| wr_en | input | 1 | Shadow write strobe |
| wr_ch | input | CH_W | Channel index of the shadow write |
| wr_delay | input | DLY_W | Delay in clock cycles for the shadow write |
| commit | input | 1 | Arms the shadow-to-active transfer |
| drive_out | output | NUM_CH | Square-wave outputs, one per channel |

## Verification
A reduced setup with four channels and periods of 10 and 16 cycles is swept across every 5-bit delay value. The value set for each channel differs, so a lane mix-up or a wrong sign in the phase subtraction shows up as a shifted wave. Values at or above the period separate correct modulo reduction from truncation or wrap-around errors. Commits are placed in the middle of a period and exactly on a wrap edge. Writes are left uncommitted, the carrier select is toggled in the middle of a period, and enable is dropped while running. Together these tell a correctly gated update apart from one that takes effect early, late or twice. Rise-to-rise spacing is measured on both carriers to confirm the period lengths.

// File: rtl/pdrv_pkg.sv
package pdrv_pkg;

    typedef enum logic [0:0] {
        BANK_IDLE  = 1'b0,
        BANK_ARMED = 1'b1
    } bank_state_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pdrv_timebase.sv
module pdrv_timebase #(
    parameter int unsigned PER_FAST = 6250,
    parameter int unsigned PER_SLOW = 10000,
    parameter int unsigned CNT_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_slow,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] per_q,
    output logic             wrap
);

    assign wrap = (cnt_q == per_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= CNT_W'(PER_FAST);
        end else if (wrap) begin
            cnt_q <= '0;
            per_q <= sel_slow ? CNT_W'(PER_SLOW) : CNT_W'(PER_FAST);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pdrv_bank.sv
module pdrv_bank
    import pdrv_pkg::*;
#(
    parameter int unsigned NUM_CH = 64,
    parameter int unsigned DLY_W  = 16,
    parameter int unsigned CH_W   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [CH_W-1:0]                wr_ch,
    input  logic [DLY_W-1:0]               wr_delay,
    input  logic                           commit,
    input  logic                           wrap,
    output logic [NUM_CH-1:0][DLY_W-1:0]   active_q,
    output logic                           armed
);

    logic [NUM_CH-1:0][DLY_W-1:0] shadow_q;
    bank_state_t                  st_q, st_d;
    logic                         swap;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[g] <= '0;
            else if (wr_en && (wr_ch == CH_W'(g)))
                shadow_q[g] <= wr_delay;
        end
    end

    // Next-state logic: arm on commit, swap on wrap, otherwise hold.
    always_comb begin
        st_d = st_q;
        swap = 1'b0;
        unique case (st_q)
            BANK_IDLE: begin
                if (commit) st_d = BANK_ARMED;
            end
            BANK_ARMED: begin
                if (wrap) begin
                    st_d = BANK_IDLE;
                    swap = 1'b1;
                end
            end
            default: st_d = BANK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= '0;
        else if (swap) active_q <= shadow_q;
    end

    assign armed = (st_q == BANK_ARMED);

endmodule

// File: rtl/pdrv_channel.sv
module pdrv_channel #(
    parameter int unsigned DLY_W = 16,
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [DLY_W-1:0] dly,
    output logic             out_q
);

    int unsigned red;
    int unsigned lag;
    logic        high;

    always_comb begin
        red = 32'(dly) % 32'(per);
        lag = 32'(cnt) + 32'(per) - red;
        if (lag >= 32'(per)) lag = lag - 32'(per);
        high = (lag < (32'(per) >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= enable & high;
    end

endmodule

// File: rtl/phased_sqwave_drv.sv
module phased_sqwave_drv
    import pdrv_pkg::*;
#(
    parameter int unsigned NUM_CH      = 64,
    parameter int unsigned DLY_W       = 16,
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned CAR_FAST_HZ = 40_000,
    parameter int unsigned CAR_SLOW_HZ = 25_000,
    localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sel_slow,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DLY_W-1:0]  wr_delay,
    input  logic              commit,
    output logic [NUM_CH-1:0] drive_out
);

    localparam int unsigned PER_FAST = CLK_HZ / CAR_FAST_HZ;
    localparam int unsigned PER_SLOW = CLK_HZ / CAR_SLOW_HZ;
    localparam int unsigned PER_MAX  = max_u(PER_FAST, PER_SLOW);
    localparam int unsigned CNT_W    = $clog2(PER_MAX + 1);

    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             per_q;
    logic                         wrap;
    logic [NUM_CH-1:0][DLY_W-1:0] active_q;
    logic                         armed;

    pdrv_timebase #(
        .PER_FAST (PER_FAST),
        .PER_SLOW (PER_SLOW),
        .CNT_W    (CNT_W)
    ) tb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_slow (sel_slow),
        .cnt_q    (cnt_q),
        .per_q    (per_q),
        .wrap     (wrap)
    );

    pdrv_bank #(
        .NUM_CH (NUM_CH),
        .DLY_W  (DLY_W),
        .CH_W   (CH_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_delay (wr_delay),
        .commit   (commit),
        .wrap     (wrap),
        .active_q (active_q),
        .armed    (armed)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pdrv_channel #(
            .DLY_W (DLY_W),
            .CNT_W (CNT_W)
        ) ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .cnt    (cnt_q),
            .per    (per_q),
            .dly    (active_q[g]),
            .out_q  (drive_out[g])
        );
    end

endmodule

// File: rtl/pdrv_chk.sv
module pdrv_chk #(
    parameter int unsigned NUM_CH = 64,
    parameter int unsigned DLY_W  = 16,
    parameter int unsigned CNT_W  = 14
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         enable,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [CNT_W-1:0]             per_q,
    input logic                         armed,
    input logic [NUM_CH-1:0][DLY_W-1:0] active_q,
    input logic [NUM_CH-1:0]            drive_out
);

    logic at_end;
    assign at_end = (cnt_q == per_q - CNT_W'(1));

    assert_outputs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (drive_out == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (cnt_q == '0));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_q);

    assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> $stable(per_q));

    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && at_end) |=> $stable(active_q));

endmodule

bind phased_sqwave_drv pdrv_chk #(
    .NUM_CH (NUM_CH),
    .DLY_W  (DLY_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cnt_q     (cnt_q),
    .per_q     (per_q),
    .armed     (armed),
    .active_q  (active_q),
    .drive_out (drive_out)
);

// File: tb/phased_sqwave_drv_tb_top.sv
`timescale 1ns/1ps
module phased_sqwave_drv_tb_top;

    localparam int NCH = 4;
    localparam int DW  = 5;
    localparam int PF  = 10;
    localparam int PS  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic           sel_slow = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic [DW-1:0]  wr_delay = '0;
    logic           commit = 1'b0;
    logic [NCH-1:0] drive_out;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    string tag = "R3";

    // Requirement-level model of the outputs
    int             m_cnt, m_per;
    int             m_act [NCH];
    int             m_shd [NCH];
    bit             m_armed;
    logic [NCH-1:0] exp_out;

    always #2 clk = ~clk;

    phased_sqwave_drv #(
        .NUM_CH      (NCH),
        .DLY_W       (DW),
        .CLK_HZ      (400_000),
        .CAR_FAST_HZ (40_000),
        .CAR_SLOW_HZ (25_000)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sel_slow  (sel_slow),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_delay  (wr_delay),
        .commit    (commit),
        .drive_out (drive_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_per <= PF; m_armed <= 1'b0; exp_out <= '0;
            for (int c = 0; c < NCH; c++) begin m_act[c] <= 0; m_shd[c] <= 0; end
        end else begin
            for (int c = 0; c < NCH; c++)
                exp_out[c] <= enable &&
                    (((m_cnt + m_per - (m_act[c] % m_per)) % m_per) < (m_per / 2));
            if (m_cnt == m_per - 1) begin
                m_cnt <= 0;
                m_per <= sel_slow ? PS : PF;
            end else begin
                m_cnt <= m_cnt + 1;
            end
            if (m_armed && (m_cnt == m_per - 1)) begin
                for (int c = 0; c < NCH; c++) m_act[c] <= m_shd[c];
                m_armed <= 1'b0;
            end else if (!m_armed && commit) begin
                m_armed <= 1'b1;
            end
            if (wr_en) m_shd[wr_ch] <= int'(wr_delay);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live)
            check(drive_out == exp_out, tag, int'(drive_out), int'(exp_out));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int ch, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_delay = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic to_last_count();
        @(negedge clk);
        while (m_cnt != m_per - 1) @(negedge clk);
    endtask

    task automatic measure_period(input int expv, input string req);
        int n;
        @(negedge clk);
        while (drive_out[0] !== 1'b0) @(negedge clk);
        while (drive_out[0] !== 1'b1) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (drive_out[0] !== 1'b0);
        while (drive_out[0] !== 1'b1) begin @(negedge clk); n++; end
        check(n == expv, req, n, expv);
    endtask

    task automatic sweep(input int per);
        for (int d = 0; d < 32; d++) begin
            int v [NCH];
            int mx;
            v[0] = d; v[1] = (d + 3) % 32; v[2] = 31 - d; v[3] = (d * 7) % 32;
            mx = 0;
            for (int c = 0; c < NCH; c++) if (v[c] > mx) mx = v[c];
            tag = (mx >= per) ? "R4" : "R3";
            for (int c = 0; c < NCH; c++) wr(c, v[c]);
            pulse_commit();
            cyc(2 * per + 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        check(drive_out == '0, "R1", int'(drive_out), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(drive_out == '0, "R1", int'(drive_out), 0);
        live = 1'b1;
        tag = "R1";
        cyc(PF);

        // R3: zero delays, all channels in phase
        tag = "R3";
        enable = 1'b1;
        cyc(2 * PF);
        measure_period(PF, "R2");

        // R3/R4 sweep on the fast carrier
        sweep(PF);

        // R5: uncommitted writes change nothing
        tag = "R5";
        for (int c = 0; c < NCH; c++) wr(c, 2 * c + 1);
        cyc(3 * PF);

        // R6: commit placed exactly on a wrap edge, then mid-period
        tag = "R6";
        to_last_count();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        cyc(2 * PF + 2);
        wr(0, 4);
        pulse_commit();
        pulse_commit();
        cyc(2 * PF + 2);

        // R7: select changed mid-period, slow carrier sweep
        tag = "R7";
        to_last_count();
        cyc(PF / 2);
        sel_slow = 1'b1;
        cyc(3 * PS);
        wr(0, 0);
        pulse_commit();
        cyc(2 * PS);
        measure_period(PS, "R2");
        sweep(PS);
        tag = "R7";
        to_last_count();
        cyc(3);
        sel_slow = 1'b0;
        cyc(3 * PS);

        // R8: enable dropped mid-run, phase kept on return
        tag = "R8";
        cyc(3);
        enable = 1'b0;
        cyc(2 * PF + 3);
        enable = 1'b1;
        cyc(2 * PF);

        live = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule